// File: doc/BRIEF.md
# Flash Program Interlock Controller

This block sequences the programming of a flash array from control register writes. Software first sets a setup bit, then loads at least one programming write into the page buffer, then sets a high-voltage enable bit to start a program pulse. Between pulses the machine sits in a margin-verify state, where verify reads decide whether another pulse is needed. While the pulse is active, array accesses are refused an acknowledge, new programming writes are turned away, and only the high-voltage enable bit of the control register can change.

A pulse-width timer runs from a 3-bit prescaler select. When the select is nonzero, the high-voltage status flag drops once the timer has counted out, so software can poll it to time the pulse. When the select is zero, the flag simply mirrors the high-voltage enable. The bench uses a synchronous master reset and a system reset, which act differently depending on the state.

Top module: `flash_pgm_interlock`

## Requirements
- R1: While `hv_en_o` is 1 (pulse state), `arr_ack_o` is 0 for any array request. In every other state, `arr_ack_o` equals `arr_req_i` in the same cycle.
- R2: `wr_accept_o` equals `prog_wr_i` in the setup, loaded and verify states. It is 0 in the idle and pulse states.
- R3: Control word layout is bit 0 high-voltage enable, bit 1 setup, bit 2 stop (write-only, reads 0) and bits 5:3 prescaler select. `ctl_o` reads back {presc, 0, setup, hv_en_o}. In the pulse state a control write leaves setup and presc unchanged.
- R4: In the pulse state, the machine moves to verify on the next cycle after any of these: a control write with enable 0, a control write with stop 1 (stop wins over enable 1), or `sysreset_i`.
- R5: In the verify state, a control write with enable 1 and setup 1 returns the machine to the pulse state.
- R6: In the verify state, a control write with setup 0 goes to idle, whatever the enable bit holds.
- R7: `mreset_i` sends the machine to idle from any state and clears setup and presc, so `ctl_o` reads 0.
- R8: With presc 0, `hv_stat_o` equals `hv_en_o`.
- R9: With presc p nonzero, `hv_stat_o` is 1 on entry to the pulse state. It drops to 0 after PW_TICKS*2^p cycles while `hv_en_o` stays 1. Each new entry to the pulse state restarts the timer.
- R10: `state_o` encodes idle=0, setup=1, loaded=2, pulse=3, verify=4. A write with setup 1 moves idle to setup. An accepted programming write moves setup to loaded. A write with enable 1 and setup 1 moves loaded to pulse. An enable write in idle or setup has no effect and reads back 0.
- R11: `sysreset_i` has no effect outside the pulse state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mreset_i | input | 1 | Synchronous master reset |
| sysreset_i | input | 1 | System reset event |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control write data |
| prog_wr_i | input | 1 | Programming write request |
| arr_req_i | input | 1 | Array access request |
| hv_en_o | output | 1 | High-voltage enable (pulse active) |
| hv_stat_o | output | 1 | High-voltage status flag |
| arr_ack_o | output | 1 | Array access acknowledge |
| wr_accept_o | output | 1 | Programming write accepted |
| state_o | output | 3 | Interlock state |
| ctl_o | output | 6 | Control register readback |

## Verification
The bench walks a full sequence: entry, alternating pulse and verify, every way out of the pulse state, and the returns to idle. After each step it probes the acknowledge and write-accept gates. A design that leaked an acknowledge or accepted a write during the pulse would show up on those gates. One write in the pulse state tries to clear setup and change presc. Lock logic that let it through would read back altered fields. Other corner cases are stop combined with enable 1, system reset outside the pulse, an early enable before any programming write, and the timer expiring and restarting on re-entry. Each of these is the case where an incomplete transition decode would take the wrong state or keep a stale status flag.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  localparam int PRESC_W = 3;
  localparam int CTL_W   = 3 + PRESC_W;
  localparam int B_HV    = 0;
  localparam int B_SETUP = 1;
  localparam int B_STOP  = 2;
  localparam int B_PRESC = 3;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_LOADED = 3'd2,
    ST_PULSE  = 3'd3,
    ST_VERIFY = 3'd4
  } pgm_state_e;
endpackage

// File: rtl/flash_pgm_regs.sv
module flash_pgm_regs
  import flash_pgm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mreset_i,
  input  logic               wr_i,
  input  logic               lock_i,
  input  logic               setup_d_i,
  input  logic [PRESC_W-1:0] presc_d_i,
  output logic               setup_o,
  output logic [PRESC_W-1:0] presc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_o <= 1'b0;
      presc_o <= '0;
    end else if (mreset_i) begin
      setup_o <= 1'b0;
      presc_o <= '0;
    end else if (wr_i && !lock_i) begin
      setup_o <= setup_d_i;
      presc_o <= presc_d_i;
    end
  end
endmodule

// File: rtl/flash_pgm_fsm.sv
module flash_pgm_fsm
  import flash_pgm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mreset_i,
  input  logic       sysreset_i,
  input  logic       ctl_wr_i,
  input  logic       w_hv_i,
  input  logic       w_setup_i,
  input  logic       w_stop_i,
  input  logic       prog_wr_i,
  output pgm_state_e state_o,
  output logic       accept_o
);
  pgm_state_e state_d;

  // programming writes land in the page buffer only in these states
  assign accept_o = prog_wr_i &&
                    (state_o == ST_SETUP || state_o == ST_LOADED || state_o == ST_VERIFY);

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE:   if (ctl_wr_i && w_setup_i) state_d = ST_SETUP;
      ST_SETUP: begin
        if (ctl_wr_i && !w_setup_i) state_d = ST_IDLE;
        else if (accept_o)          state_d = ST_LOADED;
      end
      ST_LOADED: begin
        if (ctl_wr_i && !w_setup_i) state_d = ST_IDLE;
        else if (ctl_wr_i && w_hv_i) state_d = ST_PULSE;
      end
      ST_PULSE: begin
        if (sysreset_i || (ctl_wr_i && (w_stop_i || !w_hv_i))) state_d = ST_VERIFY;
      end
      ST_VERIFY: begin
        if (ctl_wr_i && !w_setup_i) state_d = ST_IDLE;
        else if (ctl_wr_i && w_hv_i) state_d = ST_PULSE;
      end
      default:   state_d = ST_IDLE;
    endcase
    if (mreset_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/flash_pgm_timer.sv
module flash_pgm_timer
  import flash_pgm_pkg::*;
#(
  parameter int PW_TICKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               hv_stat_o
);
  localparam int DIV_W = (1 << PRESC_W) - 1;
  localparam int TW    = $clog2(PW_TICKS + 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_lim;
  logic [TW-1:0]    tick_q;
  logic             expired_q;

  // divide by 2^presc
  assign div_lim = {DIV_W{1'b1}} >> (DIV_W - int'(presc_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      tick_q    <= '0;
      expired_q <= 1'b0;
    end else if (!run_i) begin
      div_q     <= '0;
      tick_q    <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      if (div_q == div_lim) begin
        div_q <= '0;
        if (tick_q == TW'(PW_TICKS - 1)) expired_q <= 1'b1;
        else                             tick_q    <= tick_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign hv_stat_o = run_i && ((presc_i == '0) || !expired_q);
endmodule

// File: rtl/flash_pgm_interlock.sv
module flash_pgm_interlock
  import flash_pgm_pkg::*;
#(
  parameter int PW_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic             sysreset_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             prog_wr_i,
  input  logic             arr_req_i,
  output logic             hv_en_o,
  output logic             hv_stat_o,
  output logic             arr_ack_o,
  output logic             wr_accept_o,
  output logic [2:0]       state_o,
  output logic [CTL_W-1:0] ctl_o
);
  pgm_state_e         state;
  logic               setup_q;
  logic [PRESC_W-1:0] presc_q;

  flash_pgm_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mreset_i   (mreset_i),
    .sysreset_i (sysreset_i),
    .ctl_wr_i   (ctl_wr_i),
    .w_hv_i     (ctl_wdata_i[B_HV]),
    .w_setup_i  (ctl_wdata_i[B_SETUP]),
    .w_stop_i   (ctl_wdata_i[B_STOP]),
    .prog_wr_i  (prog_wr_i),
    .state_o    (state),
    .accept_o   (wr_accept_o)
  );

  assign hv_en_o = (state == ST_PULSE);

  flash_pgm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mreset_i  (mreset_i),
    .wr_i      (ctl_wr_i),
    .lock_i    (hv_en_o),
    .setup_d_i (ctl_wdata_i[B_SETUP]),
    .presc_d_i (ctl_wdata_i[B_PRESC +: PRESC_W]),
    .setup_o   (setup_q),
    .presc_o   (presc_q)
  );

  flash_pgm_timer #(.PW_TICKS(PW_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (hv_en_o),
    .presc_i   (presc_q),
    .hv_stat_o (hv_stat_o)
  );

  assign arr_ack_o = arr_req_i && !hv_en_o;
  assign state_o   = state;
  assign ctl_o     = {presc_q, 1'b0, setup_q, hv_en_o};
endmodule

// File: rtl/flash_pgm_interlock_chk.sv
module flash_pgm_interlock_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hv_en_o,
  input logic       hv_stat_o,
  input logic       arr_ack_o,
  input logic       wr_accept_o,
  input logic [2:0] state_o,
  input logic [5:0] ctl_o
);
  p_no_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> !arr_ack_o);

  p_no_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> !wr_accept_o);

  p_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_en_o && $past(hv_en_o)) |-> $stable(ctl_o[5:1]));

  p_exit_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hv_en_o) |-> (state_o == 3'd4 || state_o == 3'd0));

  p_enter_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hv_en_o) |-> ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

  p_stat_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[5:3] == 3'd0) |-> (hv_stat_o == hv_en_o));

  p_stat_in_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_stat_o |-> hv_en_o);
endmodule

bind flash_pgm_interlock flash_pgm_interlock_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hv_en_o     (hv_en_o),
  .hv_stat_o   (hv_stat_o),
  .arr_ack_o   (arr_ack_o),
  .wr_accept_o (wr_accept_o),
  .state_o     (state_o),
  .ctl_o       (ctl_o)
);

// File: tb/sim_flash_pgm_interlock.sv
`timescale 1ns/1ps
module sim_flash_pgm_interlock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mreset_i = 1'b0, sysreset_i = 1'b0, ctl_wr_i = 1'b0;
  logic [5:0] ctl_wdata_i = '0;
  logic       prog_wr_i = 1'b0, arr_req_i = 1'b0;
  logic       hv_en_o, hv_stat_o, arr_ack_o, wr_accept_o;
  logic [2:0] state_o;
  logic [5:0] ctl_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  flash_pgm_interlock #(.PW_TICKS(4)) u0 (.*);

  // {op[1:0], data[5:0], expected state[2:0]}; op 0 ctl, 1 prog, 2 sysreset, 3 mreset
  localparam logic [10:0] VEC [17] = '{
    {2'd0, 6'h01, 3'd0}, {2'd0, 6'h02, 3'd1}, {2'd0, 6'h03, 3'd1},
    {2'd1, 6'h00, 3'd2}, {2'd0, 6'h03, 3'd3}, {2'd0, 6'h02, 3'd4},
    {2'd0, 6'h03, 3'd3}, {2'd0, 6'h07, 3'd4}, {2'd0, 6'h03, 3'd3},
    {2'd2, 6'h00, 3'd4}, {2'd2, 6'h00, 3'd4}, {2'd0, 6'h03, 3'd3},
    {2'd3, 6'h00, 3'd0}, {2'd0, 6'h02, 3'd1}, {2'd1, 6'h00, 3'd2},
    {2'd0, 6'h00, 3'd0}, {2'd1, 6'h00, 3'd0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [5:0] d);
    @(negedge clk_i);
    case (op)
      2'd0: begin ctl_wr_i = 1'b1; ctl_wdata_i = d; end
      2'd1: prog_wr_i  = 1'b1;
      2'd2: sysreset_i = 1'b1;
      default: mreset_i = 1'b1;
    endcase
    @(negedge clk_i);
    ctl_wr_i = 1'b0; prog_wr_i = 1'b0; sysreset_i = 1'b0; mreset_i = 1'b0;
  endtask

  // probe gates between edges, then release before the next edge
  task automatic probe(input logic [2:0] st);
    #1 arr_req_i = 1'b1; prog_wr_i = 1'b1;
    #1;
    chk("R1 ack gate", 8'(arr_ack_o), 8'(st != 3'd3));
    chk("R2 write accept", 8'(wr_accept_o), 8'(st == 3'd1 || st == 3'd2 || st == 3'd4));
    arr_req_i = 1'b0; prog_wr_i = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 reset state", 8'(state_o), 8'd0);
    chk("R7 reset ctl", 8'(ctl_o), 8'd0);
    probe(3'd0);

    for (int i = 0; i < 17; i++) begin
      do_op(VEC[i][10:9], VEC[i][8:3]);
      chk($sformatf("R4 R5 R6 R10 R11 state step %0d", i), 8'(state_o), 8'(VEC[i][2:0]));
      chk("R8 hv_en", 8'(hv_en_o), 8'(VEC[i][2:0] == 3'd3));
      chk("R8 hv_stat presc0", 8'(hv_stat_o), 8'(VEC[i][2:0] == 3'd3));
      probe(VEC[i][2:0]);
    end

    // R10: enable ignored in idle, reads back 0
    do_op(2'd0, 6'h01);
    chk("R10 hv ignored idle", 8'(ctl_o), 8'h00);

    // R9: timer with presc=1 -> 8 cycles
    do_op(2'd0, 6'h0A);
    do_op(2'd1, 6'h00);
    do_op(2'd0, 6'h0B);
    chk("R9 pulse entered", 8'(state_o), 8'd3);
    chk("R9 stat on entry", 8'(hv_stat_o), 8'd1);
    // R3: locked fields in pulse
    do_op(2'd0, 6'h39);
    chk("R3 lock ctl", 8'(ctl_o), 8'h0B);
    chk("R3 lock state", 8'(state_o), 8'd3);
    repeat (20) @(negedge clk_i);
    chk("R9 stat expired", 8'(hv_stat_o), 8'd0);
    chk("R9 hv_en held", 8'(hv_en_o), 8'd1);
    do_op(2'd0, 6'h0A);
    chk("R4 to verify", 8'(state_o), 8'd4);
    do_op(2'd0, 6'h0B);
    chk("R9 restart state", 8'(state_o), 8'd3);
    chk("R9 restart stat", 8'(hv_stat_o), 8'd1);
    // R3: setup kept when leaving pulse with setup=0 in the write
    do_op(2'd0, 6'h08);
    chk("R3 setup held", 8'(ctl_o), 8'h0A);
    chk("R4 verify", 8'(state_o), 8'd4);
    do_op(2'd3, 6'h00);
    chk("R7 mreset ctl", 8'(ctl_o), 8'h00);
    chk("R7 mreset state", 8'(state_o), 8'd0);

    // R8: presc 0, flag stays up through a long pulse
    do_op(2'd0, 6'h02);
    do_op(2'd1, 6'h00);
    do_op(2'd0, 6'h03);
    repeat (40) @(negedge clk_i);
    chk("R8 stat follows", 8'(hv_stat_o), 8'd1);
    // R6: setup=0 with enable 1 from verify goes idle
    do_op(2'd0, 6'h02);
    do_op(2'd0, 6'h01);
    chk("R6 verify to idle", 8'(state_o), 8'd0);

    summary();
  end
endmodule